// File: doc/BRIEF.md
# UART register front end with byte FIFOs

This block is the register side of a serial port. Software reaches it over a plain 32-bit register bus. It owns two byte queues. The transmit queue is loaded by register writes and drained by a downstream serialiser over a valid/ready byte stream. The receive queue is filled by an upstream deserialiser over a second byte stream and emptied by register reads.

Besides the queues it keeps four registers. Two control registers hold an enable bit and a watermark threshold. An interrupt-enable register chooses which conditions raise the single level interrupt line. A divisor register is only stored and driven out on a port for the bit-timing logic. The pending bits are not stored: they are worked out from the queue state and the watermark fields each time they are read.

Bus reads are registered. The read value appears on `bus_rdata` in the cycle after the request and stays there until the next read. Writes take effect at the clock edge that samples them.

Top module: `uart_reg_front`

## Requirements
- R1: After reset, all of the following hold. The control, interrupt-enable, pending and divisor registers read 0 and `baud_div` is 0. A receive-data read returns 0x80000000. `tx_valid` and `irq` are low and `rx_ready` is high.
- R2: Only accesses with `bus_size` = 2'b10 (32-bit) have any effect. A write of another size changes nothing. A read of another size returns 0 and does not remove a receive byte.
- R3: A word read at offset 0x04 while the receive queue holds data returns the oldest byte in bits 7:0, with bits 31:8 zero, and removes that byte. Bytes come out in arrival order.
- R4: A word read at offset 0x04 while the receive queue is empty returns 0x80000000 (bit 31 is the empty flag) and leaves the queue unchanged.
- R5: A word write at offset 0x00 appends bits 7:0 of the write data to the 8-entry transmit queue. A write while the queue already holds 8 bytes is discarded.
- R6: A word read at offset 0x00 returns 0x80000000 while the transmit queue holds 8 bytes and 0 otherwise. The flag clears as soon as one byte leaves.
- R7: `tx_valid` is high only while bit 0 of the transmit-control register (offset 0x08) is 1 and the transmit queue is not empty. The head byte is on `tx_data`, and it leaves the queue in a cycle where `tx_valid` and `tx_ready` are both high. Bytes leave in write order, and the byte offered is held while it waits.
- R8: The pending register (offset 0x14) is read-only. Its bit 0 is 1 when bits 18:16 of the transmit-control register are nonzero. Its bit 1 is 1 when the receive byte count is strictly greater than bits 18:16 of the receive-control register (offset 0x0C).
- R9: `irq` is high when interrupt-enable (offset 0x10) bit 0 is 1, or when its bit 1 is 1 and the receive queue is not empty; it is low otherwise. It follows the state from the edge that changes it.
- R10: `rx_ready` is low while the receive queue holds 8 bytes. A byte offered while the queue is full is not stored.
- R11: The divisor register (offset 0x18) and the control and interrupt-enable registers read back the 32-bit value last written to them. The divisor is driven on `baud_div`. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_size | input | 2 | Access size, 2'b10 is 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Transmit byte at the queue head |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Downstream takes the byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receive queue has room |
| irq | output | 1 | Level interrupt |
| baud_div | output | 32 | Stored divisor value |

## Verification
A queue pointer or count that drifts shows up at the ports within one access. A receive read returns a wrong or repeated byte, or gives the empty value too early or too late. `tx_data` offers bytes out of order, or `tx_valid` stays high after the last byte. A count error also moves the full flag, `rx_ready`, the watermark pending bit and `irq` at the wrong byte. So each fill-and-drain sequence checks the count at every threshold it crosses. A register that takes a write of the wrong size, or a pending register that takes any write, shows on the next readback.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam logic [1:0] SZ_WORD    = 2'b10;
  localparam logic [4:0] OFF_TXDATA = 5'h00;
  localparam logic [4:0] OFF_RXDATA = 5'h04;
  localparam logic [4:0] OFF_TXCTRL = 5'h08;
  localparam logic [4:0] OFF_RXCTRL = 5'h0C;
  localparam logic [4:0] OFF_IE     = 5'h10;
  localparam logic [4:0] OFF_PEND   = 5'h14;
  localparam logic [4:0] OFF_DIV    = 5'h18;
  localparam int         WM_LSB     = 16;
  localparam int         IE_TX      = 0;
  localparam int         IE_RX      = 1;
  localparam int         CTRL_EN    = 0;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count)));

  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty && !push) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_fe_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq,
  output logic [31:0]       baud_div
);
  localparam int CW   = $clog2(DEPTH+1);
  localparam int WM_W = CW - 1;

  logic          acc, wr, rd;
  logic [31:0]   txctrl_q, rxctrl_q, ie_q, div_q;
  logic [31:0]   rd_val, pend;
  logic [7:0]    rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push, tx_pop, rx_push, rx_pop;

  assign acc = bus_en && (bus_size == SZ_WORD);
  assign wr  = acc && bus_we;
  assign rd  = acc && !bus_we;

  assign tx_push = wr && (bus_addr == ADDR_W'(OFF_TXDATA));
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_push = rx_valid && rx_ready;
  assign rx_pop  = rd && (bus_addr == ADDR_W'(OFF_RXDATA));

  byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_data), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty));

  byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_data),
    .pop(rx_pop), .rdata(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty));

  assign rx_ready = !rx_full;
  assign tx_valid = txctrl_q[CTRL_EN] && !tx_empty;
  assign baud_div = div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      txctrl_q <= '0;
      rxctrl_q <= '0;
      ie_q     <= '0;
      div_q    <= '0;
    end else if (wr) begin
      case (bus_addr)
        ADDR_W'(OFF_TXCTRL): txctrl_q <= bus_wdata;
        ADDR_W'(OFF_RXCTRL): rxctrl_q <= bus_wdata;
        ADDR_W'(OFF_IE):     ie_q     <= bus_wdata;
        ADDR_W'(OFF_DIV):    div_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    pend = '0;
    pend[IE_TX] = (txctrl_q[WM_LSB +: WM_W] != '0);
    pend[IE_RX] = (rx_cnt > CW'(rxctrl_q[WM_LSB +: WM_W]));
  end

  assign irq = ie_q[IE_TX] || (ie_q[IE_RX] && !rx_empty);

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_TXDATA): rd_val = {tx_full, 31'b0};
      ADDR_W'(OFF_RXDATA): rd_val = rx_empty ? 32'h8000_0000 : {24'b0, rx_head};
      ADDR_W'(OFF_TXCTRL): rd_val = txctrl_q;
      ADDR_W'(OFF_RXCTRL): rd_val = rxctrl_q;
      ADDR_W'(OFF_IE):     rd_val = ie_q;
      ADDR_W'(OFF_PEND):   rd_val = pend;
      ADDR_W'(OFF_DIV):    rd_val = div_q;
      default:             rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= (bus_size == SZ_WORD) ? rd_val : '0;
  end

  // R9
  irq_tx_en_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == ADDR_W'(OFF_IE) && bus_wdata[IE_TX]) |=> irq);

  // R4
  rx_empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> (bus_rdata == 32'h8000_0000));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !wr) |=> (tx_valid && $stable(tx_data)));

  // R2
  size_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_size != SZ_WORD) |=>
      ($stable(ie_q) && $stable(div_q) && $stable(txctrl_q) && $stable(rxctrl_q)));
endmodule

// File: tb/sim_uart_reg_front.sv
`timescale 1ns/1ps
module sim_uart_reg_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        irq;
  logic [31:0] baud_div;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_reg_front u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_size = 2'b10;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic [1:0] sz = 2'b10);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_en = 0; bus_size = 2'b10;
    d = bus_rdata;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic tx_take(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk({tag, " valid"}, {31'b0, tx_valid}, 32'd1);
    chk({tag, " data"}, {24'b0, tx_data}, {24'b0, exp});
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h08, v); chk("R1 txctrl", v, 0);
    rd(5'h0C, v); chk("R1 rxctrl", v, 0);
    rd(5'h10, v); chk("R1 ie", v, 0);
    rd(5'h14, v); chk("R1 pend", v, 0);
    rd(5'h18, v); chk("R1 div", v, 0);
    rd(5'h04, v); chk("R1 rx empty", v, 32'h8000_0000);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    chk("R1 baud_div", baud_div, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(5'h18, 32'h1234_5678);
    rd(5'h18, v); chk("R11 div rb", v, 32'h1234_5678);
    chk("R11 baud_div", baud_div, 32'h1234_5678);
    wr(5'h0C, 32'h00A5_5A00);
    rd(5'h0C, v); chk("R11 rxctrl rb", v, 32'h00A5_5A00);
    wr(5'h0C, 32'h0);
    rd(5'h1C, v); chk("R11 undefined", v, 0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R8 pend ro", v, 0);
  endtask

  task automatic t_size;
    logic [31:0] v;
    wr(5'h18, 32'h0000_AAAA, 2'b01);
    rd(5'h18, v); chk("R2 div kept", v, 32'h1234_5678);
    wr(5'h00, 32'h0000_0077, 2'b00);
    wr(5'h08, 32'h1);
    @(negedge clk); chk("R2 tx not pushed", {31'b0, tx_valid}, 0);
    wr(5'h08, 32'h0);
    rx_put(8'h5C);
    rd(5'h04, v, 2'b00); chk("R2 narrow read zero", v, 0);
    rd(5'h04, v); chk("R2 byte kept", v, 32'h5C);
  endtask

  task automatic t_rx_order;
    logic [31:0] v;
    rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
    rd(5'h04, v); chk("R3 first", v, 32'h11);
    rd(5'h04, v); chk("R3 second", v, 32'h22);
    rd(5'h04, v); chk("R3 third", v, 32'h33);
    rd(5'h04, v); chk("R4 empty", v, 32'h8000_0000);
    rd(5'h04, v); chk("R4 empty again", v, 32'h8000_0000);
    rx_put(8'h44);
    rd(5'h04, v); chk("R4 unchanged", v, 32'h44);
  endtask

  task automatic t_rx_full;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk("R10 ready before fill", {31'b0, rx_ready}, 1);
      rx_put(8'(i * 3 + 1));
    end
    @(negedge clk); chk("R10 ready low", {31'b0, rx_ready}, 0);
    rx_put(8'hEE);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, v); chk("R10 drain", v, 32'(i * 3 + 1));
    end
    rd(5'h04, v); chk("R10 dropped byte", v, 32'h8000_0000);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    wr(5'h0C, 32'h0002_0000);
    rx_put(8'h01); rx_put(8'h02);
    rd(5'h14, v); chk("R8 rx at wm", v, 0);
    rx_put(8'h03);
    rd(5'h14, v); chk("R8 rx above wm", v, 32'h2);
    wr(5'h08, 32'h0001_0000);
    rd(5'h14, v); chk("R8 tx wm", v, 32'h3);
    wr(5'h08, 32'h0000_0001);
    rd(5'h14, v); chk("R8 en bit not wm", v, 32'h2);
    wr(5'h08, 0); wr(5'h0C, 0);
    for (int i = 0; i < 3; i++) rd(5'h04, v);
    rd(5'h14, v); chk("R8 cleared", v, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(5'h10, 32'h2);
    @(negedge clk); chk("R9 rx en empty", {31'b0, irq}, 0);
    rx_put(8'h9A);
    chk("R9 rx en data", {31'b0, irq}, 1);
    rd(5'h04, v);
    chk("R9 rx drained", {31'b0, irq}, 0);
    wr(5'h10, 32'h1);
    chk("R9 tx en", {31'b0, irq}, 1);
    wr(5'h10, 32'h0);
    chk("R9 off", {31'b0, irq}, 0);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    wr(5'h08, 32'h0);
    for (int i = 0; i < 9; i++) wr(5'h00, 32'hFFFF_FF00 | 32'(8'hA0 + i));
    rd(5'h00, v); chk("R6 full flag", v, 32'h8000_0000);
    chk("R7 gated off", {31'b0, tx_valid}, 0);
    wr(5'h08, 32'h1);
    @(negedge clk); @(negedge clk);
    chk("R7 held data", {24'b0, tx_data}, 32'hA0);
    tx_take("R7 byte0", 8'hA0);
    rd(5'h00, v); chk("R6 flag cleared", v, 0);
    for (int i = 1; i < 8; i++) tx_take("R5 order", 8'(8'hA0 + i));
    @(negedge clk); chk("R5 ninth discarded", {31'b0, tx_valid}, 0);
    wr(5'h08, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_regs();
    t_size();
    t_rx_order();
    t_rx_full();
    t_pending();
    t_irq();
    t_tx();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule